// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory. An address strobe captures a full external address. The two low bits become the burst start offset, and the remaining high bits are held unchanged for the whole burst. On every following clock edge where the advance input is asserted, the block moves to the next beat. The offset follows either a linear order (count up, modulo four) or an interleaved order (start offset XOR beat count). A mode input chooses between them. When advance is released, the burst is suspended and the address holds. After the fourth beat the sequence wraps back to the start offset.

A small state machine has two states. ST_IDLE is entered on reset: no start address has been captured yet, so advance is ignored. ST_BURST is entered from ST_IDLE on the first strobe (transition IDLE->BURST). It stays there on every later cycle (transition BURST->BURST), and any strobe reloads the start and beat count. Only reset returns the machine to ST_IDLE (transition any->IDLE).

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset `rst` sampled at a rising edge clears `beat_idx` to 0 and `addr_out` to all zeros from that edge on.
- R2: At a rising edge where `ld_n` is 0, the block captures `addr_in`. After that edge, `addr_out` equals the captured address and `beat_idx` is 0, in either mode.
- R3: A strobe takes priority over advance. When `ld_n` and `adv_n` are both 0 at the same edge, including in the middle of a burst, the block reloads as in R2 and does not step.
- R4: With `mode_sel` = 0 (linear), `addr_out[1:0]` = (start + `beat_idx`) mod 4. For example, start 2 gives offsets 2, 3, 0, 1.
- R5: With `mode_sel` = 1 (interleaved), `addr_out[1:0]` = start XOR `beat_idx`. This gives 0,1,2,3 / 1,0,3,2 / 2,3,0,1 / 3,2,1,0 for starts 0 to 3.
- R6: In ST_BURST, each rising edge with `adv_n` = 0 and `ld_n` = 1 increments `beat_idx` by one. An edge with both inputs at 1 leaves `beat_idx` and `addr_out` unchanged (suspend).
- R7: After four advances `beat_idx` wraps to 0, and `addr_out[1:0]` returns to the start offset.
- R8: In ST_IDLE (after reset and before any strobe), advance has no effect: `beat_idx` stays 0 and `addr_out` stays 0.
- R9: `mode_sel` is applied combinationally every cycle. Changing it in the middle of a burst changes `addr_out[1:0]` in the same cycle, using the current beat count, with no clock edge needed.
- R10: `addr_out[ADDR_W-1:2]` holds the high bits captured at the last strobe and does not change on advance or suspend edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_n | input | 1 | Address strobe, active low; loads `addr_in` |
| adv_n | input | 1 | Advance, active low; steps the burst |
| mode_sel | input | 1 | Order select: 0 linear, 1 interleaved (tie high when unused) |
| addr_in | input | ADDR_W | External address presented with the strobe |
| addr_out | output | ADDR_W | Current burst address: held high bits and burst offset |
| beat_idx | output | 2 | Beat count within the burst, 0 to 3 |

## Verification
Strobe, advance and reset take effect at one rising edge, through a single register stage. Their results are therefore sampled at the falling edge that follows that rising edge. A mode change has no register in its path, so its effect is sampled one time unit after the change, with no clock edge in between. Inputs change only on falling edges, so each check sees exactly one edge's worth of change. The bench compares every start offset in both orders, beat by beat through the wrap, against fixed tables of expected offsets.

// File: rtl/burst_pkg.sv
package burst_pkg;
    // Four beats per burst, so the offset and the beat count are two bits wide.
    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bst_t;

    typedef enum logic [0:0] {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } ord_t;
endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output bst_t state,
    output ofs_t beat
);
    bst_t state_nx;
    ofs_t beat_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
        end
    end

    // Next state and beat count.
    always_comb begin
        state_nx = state;
        beat_nx  = beat;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    state_nx = ST_BURST;
                    beat_nx  = '0;
                end
            end
            ST_BURST: begin
                if (load) begin
                    beat_nx = '0;
                end else if (step) begin
                    beat_nx = beat + ofs_t'(1);
                end
            end
            default: begin
                state_nx = ST_IDLE;
                beat_nx  = '0;
            end
        endcase
    end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    localparam int HI_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output ofs_t              start,
    output logic [HI_W-1:0]   upper
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start <= '0;
            upper <= '0;
        end else if (load) begin
            start <= addr_in[OFS_W-1:0];
            upper <= addr_in[ADDR_W-1:OFS_W];
        end
    end
endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_pkg::*;
(
    input  ofs_t start,
    input  ofs_t beat,
    input  ord_t order,
    output ofs_t ofs
);
    ofs_t lin_ofs;
    ofs_t ilv_ofs;

    always_comb begin
        lin_ofs = start + beat;
        ilv_ofs = start ^ beat;
        unique case (order)
            ORD_LINEAR:     ofs = lin_ofs;
            ORD_INTERLEAVE: ofs = ilv_ofs;
            default:        ofs = ilv_ofs;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              adv_n,
    input  logic              mode_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [OFS_W-1:0]  beat_idx
);
    localparam int HI_W = ADDR_W - OFS_W;

    logic            load;
    logic            step;
    bst_t            st;
    ofs_t            beat;
    ofs_t            start;
    ofs_t            ofs;
    logic [HI_W-1:0] upper;
    ord_t            order;

    assign load  = ~ld_n;
    assign step  = ~adv_n;
    assign order = mode_sel ? ORD_INTERLEAVE : ORD_LINEAR;

    burst_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (step),
        .state (st),
        .beat  (beat)
    );

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_in (addr_in),
        .start   (start),
        .upper   (upper)
    );

    burst_order u_order (
        .start (start),
        .beat  (beat),
        .order (order),
        .ofs   (ofs)
    );

    assign addr_out = {upper, ofs};
    assign beat_idx = beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [OFS_W-1:0]  beat_idx,
    input bst_t              st
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (beat_idx == '0 && addr_out == '0)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !ld_n |=> (addr_out == $past(addr_in) && beat_idx == '0)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !adv_n && st == ST_BURST) |=>
            beat_idx == OFS_W'($past(beat_idx) + 1'b1)); // R6

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_n && adv_n) |=> $stable(beat_idx)); // R6

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (ld_n && st == ST_IDLE) |=> beat_idx == '0); // R8

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(addr_out[ADDR_W-1:OFS_W])); // R10
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_n     (ld_n),
    .adv_n    (adv_n),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .beat_idx (beat_idx),
    .st       (st)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic          ld_n;
    logic          adv_n;
    logic          mode_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;

    int nvec = 0;
    int nbad = 0;

    // Expected offsets, indexed [start*4 + beat].
    logic [1:0] lin_tab [16] = '{2'd0,2'd1,2'd2,2'd3, 2'd1,2'd2,2'd3,2'd0,
                                 2'd2,2'd3,2'd0,2'd1, 2'd3,2'd0,2'd1,2'd2};
    logic [1:0] ilv_tab [16] = '{2'd0,2'd1,2'd2,2'd3, 2'd1,2'd0,2'd3,2'd2,
                                 2'd2,2'd3,2'd0,2'd1, 2'd3,2'd2,2'd1,2'd0};

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .ld_n     (ld_n),
        .adv_n    (adv_n),
        .mode_sel (mode_sel),
        .addr_in  (addr_in),
        .addr_out (addr_out),
        .beat_idx (beat_idx)
    );

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // One rising edge with the given controls; returns at the next falling edge.
    task automatic edge_with(input logic l, input logic a, input logic [AW-1:0] ad);
        ld_n = l; adv_n = a; addr_in = ad;
        @(posedge clk);
        @(negedge clk);
        ld_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 beat", AW'(beat_idx), '0);
        check("R1 addr", addr_out, '0);
    endtask

    task automatic t_idle_adv();
        do_reset();
        for (int i = 0; i < 3; i++) edge_with(1'b1, 1'b0, '1);
        check("R8 beat", AW'(beat_idx), '0);
        check("R8 addr", addr_out, '0);
    endtask

    task automatic t_sweep(input logic m);
        logic [AW-1:0] base;
        base = AW'(17'h0A5F0);
        mode_sel = m;
        for (int s = 0; s < 4; s++) begin
            edge_with(1'b0, 1'b1, base | AW'(s));
            check("R2 load addr", addr_out, base | AW'(s));
            check("R2 load beat", AW'(beat_idx), '0);
            for (int b = 1; b <= 4; b++) begin
                edge_with(1'b1, 1'b0, '0);
                check(m ? "R5 interleaved ofs" : "R4 linear ofs", AW'(addr_out[1:0]),
                      AW'(m ? ilv_tab[s*4 + (b%4)] : lin_tab[s*4 + (b%4)]));
                check("R6 beat", AW'(beat_idx), AW'(b % 4));
                check("R10 upper", addr_out >> 2, base >> 2);
            end
            check("R7 wrap to start", AW'(addr_out[1:0]), AW'(s));
        end
    endtask

    task automatic t_suspend();
        mode_sel = 1'b1;
        edge_with(1'b0, 1'b1, AW'(17'h00003));
        edge_with(1'b1, 1'b0, '0);
        for (int i = 0; i < 3; i++) edge_with(1'b1, 1'b1, '1);
        check("R6 suspend beat", AW'(beat_idx), AW'(1));
        check("R6 suspend addr", addr_out, AW'(17'h00002));
    endtask

    task automatic t_reload_priority();
        mode_sel = 1'b0;
        edge_with(1'b0, 1'b1, AW'(17'h10002));
        edge_with(1'b1, 1'b0, '0);
        check("R4 mid ofs", AW'(addr_out[1:0]), AW'(3));
        edge_with(1'b0, 1'b0, AW'(17'h04441));
        check("R3 reload addr", addr_out, AW'(17'h04441));
        check("R3 reload beat", AW'(beat_idx), '0);
    endtask

    task automatic t_mode_switch();
        mode_sel = 1'b1;
        edge_with(1'b0, 1'b1, AW'(17'h00001));
        edge_with(1'b1, 1'b0, '0);
        check("R9 interleaved ofs", AW'(addr_out[1:0]), AW'(0));
        mode_sel = 1'b0;
        #1;
        check("R9 linear ofs", AW'(addr_out[1:0]), AW'(2));
        check("R9 beat kept", AW'(beat_idx), AW'(1));
    endtask

    initial begin
        #800000;
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_n = 1'b1; adv_n = 1'b1; mode_sel = 1'b1; addr_in = '0;
        t_reset();
        t_idle_adv();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_suspend();
        t_reload_priority();
        t_mode_switch();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule